// File: doc/BRIEF.md
# Receive FIFO Automatic Request-to-Send Controller

This block holds a UART receiver's incoming characters in a small first-in first-out buffer. It drives the active-low request-to-send line, `rts_n`, from how full that buffer is. When automatic flow control is engaged, `rts_n` goes inactive (high) once the buffer reaches a selectable near-full level. This tells the far-end transmitter to pause. The line returns active (low) only after software has read the buffer all the way to empty. The high level and the empty level are far apart, so the line does not toggle once per character.

Automatic control needs three enables at once: the manual request bit, the automatic-flow enable and the buffer enable. In every other case `rts_n` just follows the inverse of the manual request bit. The buffer still has room above the highest threshold, so a character that the far end had already started after `rts_n` rose is kept. A write into a full buffer is discarded and raises a sticky overrun flag, which software clears.

Top module: `uart_rx_flow_ctrl`

## Requirements
- R1: `auto_active` is 1 exactly when `rts_manual`, `afc_en` and `fifo_en` are all 1; it is combinational from those inputs.
- R2: While `auto_active` is 0, `rts_n` takes the value `~rts_manual` on the next rising clock edge.
- R3: `thr_sel` selects the pause level: 2'b00 = 1 entry, 2'b01 = DEPTH/4, 2'b10 = DEPTH/2, 2'b11 = DEPTH-2. While automatic mode is active, `rts_n` is 1 on the clock edge after the edge at which `level` first reaches or exceeds that level.
- R4: Once `rts_n` is high in automatic mode, it stays high while `level` is nonzero, even after `level` drops below the pause level.
- R5: In automatic mode, `rts_n` goes low on the clock edge after the one at which `level` becomes 0.
- R6: Clearing `fifo_en` returns `rts_n` to manual control (`~rts_manual`) on the next edge, whatever the other bits are. When automatic mode is entered again, the held state starts cleared.
- R7: The buffer keeps accepting writes after `rts_n` rises, up to DEPTH entries, and it returns entries in write order. `pop_data` shows the oldest entry while `empty` is 0.
- R8: A `push` while `full` is 1 and without a `pop` is dropped, and `level` is unchanged. `overrun` then reads 1 from the next edge on and stays 1 until a cycle with `ovr_clr` high; a drop in that same cycle takes priority.
- R9: Synchronous reset drives `rts_n` to 1, `level` to 0 and `overrun` to 0, and clears the held automatic state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Write one received character |
| push_data | input | DW | Character to write |
| pop | input | 1 | Read (remove) the oldest character |
| pop_data | output | DW | Oldest character, valid while not empty |
| fifo_en | input | 1 | Buffer enable; gates automatic control |
| rts_manual | input | 1 | Manual request-to-send bit |
| afc_en | input | 1 | Automatic flow-control enable |
| thr_sel | input | 2 | Pause level select (see R3) |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| level | output | $clog2(DEPTH+1) | Current occupancy |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| overrun | output | 1 | Sticky flag: a write was dropped |
| rts_n | output | 1 | Registered active-low request-to-send |
| auto_active | output | 1 | Automatic control is engaged |

## Verification
The bench builds the block with DEPTH = 16 and DW = 8. With that depth all four pause levels (1, 4, 8 and 14) can be reached in a few dozen cycles. The buffer can also be filled past the top pause level to full and then overrun. With 8-bit data, every character written in a full run is unique, so the scoreboard can detect reordering or loss across a complete fill and drain.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    typedef enum logic [1:0] {
        THR_ONE       = 2'b00,
        THR_QUARTER   = 2'b01,
        THR_HALF      = 2'b10,
        THR_NEAR_FULL = 2'b11
    } thr_sel_e;

    typedef struct packed {
        logic     fifo_en;
        logic     rts_manual;
        logic     afc_en;
        thr_sel_e sel;
    } flow_cfg_t;

    // Occupancy at which the far end is asked to pause.
    function automatic int unsigned pause_level(logic [1:0] sel, int unsigned depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rfc_fifo.sv
module rfc_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    input  logic                         ovr_clr,
    output logic [DW-1:0]                pop_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty,
    output logic                         overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          rd_ok, wr_ok, drop;

    assign full  = (cnt == CNT_MAX);
    assign empty = (cnt == '0);
    assign rd_ok = pop && !empty;
    assign wr_ok = push && (!full || rd_ok);
    assign drop  = push && !wr_ok;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            cnt     <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
            if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
            case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
            if (drop)         overrun <= 1'b1;
            else if (ovr_clr) overrun <= 1'b0;
        end
    end

    assign pop_data = mem[rd_ptr];
    assign level    = cnt;

endmodule

// File: rtl/rfc_thresh.sv
module rfc_thresh #(
    parameter int DEPTH = 16
) (
    input  rfc_pkg::thr_sel_e            sel,
    input  logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         reach
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] LVL_ONE  = CW'(rfc_pkg::pause_level(2'b00, DEPTH));
    localparam logic [CW-1:0] LVL_QTR  = CW'(rfc_pkg::pause_level(2'b01, DEPTH));
    localparam logic [CW-1:0] LVL_HALF = CW'(rfc_pkg::pause_level(2'b10, DEPTH));
    localparam logic [CW-1:0] LVL_NF   = CW'(rfc_pkg::pause_level(2'b11, DEPTH));

    logic [CW-1:0] limit;

    always_comb begin
        case (sel)
            rfc_pkg::THR_ONE:     limit = LVL_ONE;
            rfc_pkg::THR_QUARTER: limit = LVL_QTR;
            rfc_pkg::THR_HALF:    limit = LVL_HALF;
            default:              limit = LVL_NF;
        endcase
    end

    assign reach = (level >= limit);

endmodule

// File: rtl/rfc_rts_ctrl.sv
module rfc_rts_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic auto_on,
    input  logic rts_manual,
    input  logic reach,
    input  logic empty,
    output logic rts_n
);
    logic held, held_next, rts_n_next;

    // Hysteresis: pause at threshold, release only on empty.
    always_comb begin
        held_next  = held ? !empty : reach;
        rts_n_next = auto_on ? held_next : !rts_manual;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= 1'b0;
            rts_n <= 1'b1;
        end else begin
            held  <= auto_on ? held_next : 1'b0;
            rts_n <= rts_n_next;
        end
    end

endmodule

// File: rtl/uart_rx_flow_ctrl.sv
module uart_rx_flow_ctrl #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  logic [DW-1:0]               push_data,
    input  logic                        pop,
    output logic [DW-1:0]               pop_data,
    input  logic                        fifo_en,
    input  logic                        rts_manual,
    input  logic                        afc_en,
    input  logic [1:0]                  thr_sel,
    input  logic                        ovr_clr,
    output logic [$clog2(DEPTH+1)-1:0]  level,
    output logic                        full,
    output logic                        empty,
    output logic                        overrun,
    output logic                        rts_n,
    output logic                        auto_active
);
    rfc_pkg::flow_cfg_t cfg;
    logic reach;

    assign cfg = '{fifo_en:    fifo_en,
                   rts_manual: rts_manual,
                   afc_en:     afc_en,
                   sel:        rfc_pkg::thr_sel_e'(thr_sel)};

    assign auto_active = cfg.fifo_en && cfg.rts_manual && cfg.afc_en;

    rfc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .ovr_clr   (ovr_clr),
        .pop_data  (pop_data),
        .level     (level),
        .full      (full),
        .empty     (empty),
        .overrun   (overrun)
    );

    rfc_thresh #(.DEPTH(DEPTH)) u_thresh (
        .sel   (cfg.sel),
        .level (level),
        .reach (reach)
    );

    rfc_rts_ctrl u_rts (
        .clk        (clk),
        .rst        (rst),
        .auto_on    (auto_active),
        .rts_manual (cfg.rts_manual),
        .reach      (reach),
        .empty      (empty),
        .rts_n      (rts_n)
    );

endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
    parameter int DEPTH = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        push,
    input logic                        pop,
    input logic                        full,
    input logic [$clog2(DEPTH+1)-1:0]  level,
    input logic                        overrun,
    input logic                        rts_n,
    input logic                        auto_active,
    input logic                        rts_manual,
    input logic [1:0]                  thr_sel
);
    a_r2_manual_follow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(auto_active)) |-> (rts_n == !$past(rts_manual)));

    a_r3_pause_at_level: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(auto_active) &&
         (32'($past(level)) >= rfc_pkg::pause_level($past(thr_sel), DEPTH))) |-> rts_n);

    a_r4_hold_while_nonempty: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(auto_active) && $past(auto_active, 2) &&
         $past(rts_n) && ($past(level) != '0)) |-> rts_n);

    a_r5_release_on_empty: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(auto_active) && ($past(level) == '0)) |-> !rts_n);

    a_r7_level_bound: assert property (@(posedge clk) disable iff (rst)
        32'(level) <= DEPTH);

    a_r8_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (overrun && $stable(level)));

endmodule

bind uart_rx_flow_ctrl rfc_checker #(.DEPTH(DEPTH)) u_rfc_checker (
    .clk         (clk),
    .rst         (rst),
    .push        (push),
    .pop         (pop),
    .full        (full),
    .level       (level),
    .overrun     (overrun),
    .rts_n       (rts_n),
    .auto_active (auto_active),
    .rts_manual  (rts_manual),
    .thr_sel     (thr_sel)
);

// File: tb/uart_rx_flow_ctrl_tb_top.sv
module uart_rx_flow_ctrl_tb_top;
    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH+1);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1, push = 1'b0, pop = 1'b0;
    logic [DW-1:0] push_data = '0, pop_data;
    logic          fifo_en = 1'b0, rts_manual = 1'b0, afc_en = 1'b0, ovr_clr = 1'b0;
    logic [1:0]    thr_sel = 2'b00;
    logic [CW-1:0] level;
    logic          full, empty, overrun, rts_n, auto_active;

    uart_rx_flow_ctrl #(.DW(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .fifo_en(fifo_en), .rts_manual(rts_manual),
        .afc_en(afc_en), .thr_sel(thr_sel), .ovr_clr(ovr_clr), .level(level),
        .full(full), .empty(empty), .overrun(overrun), .rts_n(rts_n),
        .auto_active(auto_active)
    );

    int total = 0, bad = 0, mlvl = 0;
    bit done = 0;
    logic [DW-1:0] sb_q [$];

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Driver: predicts acceptance and queues the expected character.
    task automatic push_one(logic [DW-1:0] d);
        push = 1'b1; push_data = d;
        if (mlvl < DEPTH) begin
            sb_q.push_back(d);
            mlvl++;
        end
        tick();
        push = 1'b0;
    endtask

    task automatic pop_one();
        pop = 1'b1;
        tick();
        pop = 1'b0;
        if (mlvl > 0) mlvl--;
    endtask

    // Monitor: compares the head shown while a read is requested (R7).
    always @(negedge clk) begin
        if (!rst && pop && !empty) begin
            if (sb_q.size() == 0) chk("R7 unexpected data", 1, 0);
            else chk("R7 order", int'(pop_data), int'(sb_q.pop_front()));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R9 rts_n in reset", rts_n, 1);
        chk("R9 level in reset", level, 0);
        rst = 1'b0;
        tick();
        chk("R9 rts_n after reset", rts_n, 1);
        chk("R9 overrun after reset", overrun, 0);
        chk("R9 empty after reset", empty, 1);

        // Manual mode
        fifo_en = 1'b1; rts_manual = 1'b1;
        tick();
        chk("R1 auto off without afc_en", auto_active, 0);
        chk("R2 manual rts high", rts_n, 0);
        rts_manual = 1'b0;
        tick();
        chk("R2 manual rts low", rts_n, 1);

        // Automatic, quarter level = 4
        rts_manual = 1'b1; afc_en = 1'b1; thr_sel = 2'b01;
        tick();
        chk("R1 auto engaged", auto_active, 1);
        chk("R5 idle auto rts_n", rts_n, 0);
        for (int i = 1; i <= 3; i++) push_one(DW'(i));
        tick();
        chk("R3 below quarter", rts_n, 0);
        push_one(8'd4);
        chk("R3 one edge latency", rts_n, 0);
        tick();
        chk("R3 quarter reached", rts_n, 1);
        pop_one(); pop_one();
        tick();
        chk("R4 held below level", rts_n, 1);
        pop_one(); pop_one();
        chk("R4 held until empty seen", rts_n, 1);
        tick();
        chk("R5 release on empty", rts_n, 0);

        // Near-full level = 14, then full and overrun
        thr_sel = 2'b11;
        for (int i = 0; i < 13; i++) push_one(DW'(16 + i));
        tick();
        chk("R3 below near-full", rts_n, 0);
        push_one(8'd29);
        tick();
        chk("R3 near-full reached", rts_n, 1);
        push_one(8'd30); push_one(8'd31);
        chk("R7 accepts past pause", level, 16);
        chk("R7 full flag", full, 1);
        push_one(8'd99);
        chk("R8 overrun set", overrun, 1);
        chk("R8 level unchanged", level, 16);
        tick();
        chk("R8 overrun sticky", overrun, 1);
        ovr_clr = 1'b1;
        tick();
        ovr_clr = 1'b0;
        chk("R8 overrun cleared", overrun, 0);

        // FIFO disable overrides
        fifo_en = 1'b0;
        tick();
        chk("R6 auto off", auto_active, 0);
        chk("R6 manual control", rts_n, 0);
        fifo_en = 1'b1;
        tick();
        chk("R6 re-engaged at level", rts_n, 1);
        for (int i = 0; i < 16; i++) pop_one();
        tick();
        chk("R5 drained", rts_n, 0);
        chk("R7 queue drained", sb_q.size(), 0);

        // One-entry level
        thr_sel = 2'b00;
        push_one(8'd50);
        tick();
        chk("R3 one-entry level", rts_n, 1);
        pop_one();
        tick();
        chk("R5 release one-entry", rts_n, 0);

        // Half level = 8
        thr_sel = 2'b10;
        for (int i = 0; i < 7; i++) push_one(DW'(60 + i));
        tick();
        chk("R3 below half", rts_n, 0);
        push_one(8'd70);
        tick();
        chk("R3 half reached", rts_n, 1);

        // Reset clears everything
        rst = 1'b1;
        tick();
        sb_q.delete(); mlvl = 0;
        chk("R9 rts_n on reset", rts_n, 1);
        chk("R9 level on reset", level, 0);
        rst = 1'b0;
        tick();
        chk("R9 hysteresis cleared", rts_n, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule